// File: doc/BRIEF.md
# Dual-Bank Byte-Lane SRAM Array

This block is a synthesizable behavioural model of a word-addressed static memory, 32 bits wide, split into two 16-bit halves. Each half has its own active-low chip select. Four active-low byte selects, plus a shared active-low write enable and a shared active-low output enable, decide for each access which byte lanes are written, which are driven back and which stay undriven. Because each half has its own select, one word can be partly written or read while the other half idles in standby.

Each access is carried by a valid/ready request. The controls, address and write data travel with the request. One accepted request is handled per clock. Every accepted request, including a write or a standby access, produces exactly one response. The response carries the read word and a per-lane drive vector. The drive vector stands in for the tristate enables of a real bidirectional bus. A lane that is not driven returns zero.

A request is accepted when `req_ready` is high. That is true when no response is pending or when the pending response is taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no request is accepted. The `standby` pin reports on the most recently accepted request. Memory contents are not reset. The depth is 2^`ADDR_W` words: the default of 10 keeps elaboration small, and setting `ADDR_W` to 16 gives the full 65,536-word array.

Top module: `dual_bank_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of 32 bits. A word written at an address reads back unchanged at that address, including the lowest and highest addresses.
- R2: `req_cs_n[0]` gates data bits 15:0 (lanes 0 and 1). `req_cs_n[1]` gates data bits 31:16 (lanes 2 and 3).
- R3: `req_bs_n[k]` selects lane k, which is data bits 8k+7 down to 8k. An unselected lane is neither written nor driven.
- R4: A lane is written when its half's chip select is 0, `req_we_n` is 0 and its byte select is 0. `req_oe_n` has no effect during a write, and a write response drives no lane.
- R5: A lane is driven when its half's chip select is 0, `req_we_n` is 1, `req_oe_n` is 0 and its byte select is 0. A driven lane returns its stored byte with its `rsp_lane_oe` bit at 1. An undriven lane returns 0 with its bit at 0.
- R6: When `req_we_n` and `req_oe_n` are both 1, no lane is written and no lane is driven, even with both halves selected.
- R7: When one half's chip select is 1, that half ignores its byte selects: it is neither written nor driven. The other half still operates normally.
- R8: `standby` is 1 exactly when both chip selects of the most recently accepted request were 1. Such a request writes nothing and drives no lane.
- R9: `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. Each accepted request yields one response, in order. A stalled response keeps its data, drive vector and `standby` unchanged.
- R10: After reset, `rsp_valid` is 0, `rsp_lane_oe` is 0, `standby` is 1 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_cs_n | input | 2 | Active-low chip select per half (bit 0: low half) |
| req_bs_n | input | 4 | Active-low byte select per lane |
| req_we_n | input | 1 | Active-low write enable |
| req_oe_n | input | 1 | Active-low output enable |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, zero on undriven lanes |
| rsp_lane_oe | output | 4 | Per-lane drive indication |
| standby | output | 1 | Last accepted request deselected both halves |

## Verification
A lane decoded to the wrong half or select would show up on the very next response as a wrong `rsp_lane_oe` bit. A bad write gate would stay hidden until a later read of the same address, where the scoreboard compares that lane with its shadow copy. A response register that moves while stalled, or a ready that ignores back-pressure, would make the scoreboard see a lost, duplicated or changed response as soon as the stall ends. The bench therefore mixes single-lane, single-half, idle and standby accesses at the address extremes with a randomized phase under random back-pressure.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANE_W         = 8;
  localparam int LANES          = 4;
  localparam int HALVES         = 2;
  localparam int DATA_W         = LANE_W * LANES;
  localparam int LANES_PER_HALF = LANES / HALVES;

  typedef struct packed {
    logic [HALVES-1:0] cs_n;
    logic [LANES-1:0]  bs_n;
    logic              we_n;
    logic              oe_n;
  } ctl_t;
endpackage

// File: rtl/dbs_lane_decode.sv
module dbs_lane_decode
  import dbs_pkg::*;
(
  input  ctl_t             ctl,
  output logic [LANES-1:0] wr_en,
  output logic [LANES-1:0] rd_en,
  output logic             standby
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HALF = k / LANES_PER_HALF;
    logic lane_on;
    assign lane_on  = !ctl.cs_n[HALF] && !ctl.bs_n[k];
    assign wr_en[k] = lane_on && !ctl.we_n;
    assign rd_en[k] = lane_on && ctl.we_n && !ctl.oe_n;
  end

  assign standby = &ctl.cs_n;
endmodule

// File: rtl/dbs_byte_bank.sv
module dbs_byte_bank #(
  parameter int ADDR_W = 10,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  // Storage carries no reset; only the read register does.
  always_ff @(posedge clk) begin
    if (accept && wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (accept) q <= rd_en ? mem[addr] : '0;
  end
endmodule

// File: rtl/dbs_resp_stage.sv
module dbs_resp_stage
  import dbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             rsp_ready,
  input  logic [LANES-1:0] rd_en,
  input  logic             standby_in,
  output logic             req_ready,
  output logic             accept,
  output logic             rsp_valid,
  output logic [LANES-1:0] lane_oe,
  output logic             standby
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      lane_oe   <= '0;
      standby   <= 1'b1;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      lane_oe   <= rd_en;
      standby   <= standby_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_bank_sram.sv
module dual_bank_sram
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [HALVES-1:0]   req_cs_n,
  input  logic [LANES-1:0]    req_bs_n,
  input  logic                req_we_n,
  input  logic                req_oe_n,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [LANES-1:0]    rsp_lane_oe,
  output logic                standby
);
  ctl_t             ctl;
  logic [LANES-1:0] wr_en;
  logic [LANES-1:0] rd_en;
  logic             sb_next;
  logic             accept;

  assign ctl = '{cs_n: req_cs_n, bs_n: req_bs_n, we_n: req_we_n, oe_n: req_oe_n};

  dbs_lane_decode u_dec (
    .ctl     (ctl),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .standby (sb_next)
  );

  dbs_resp_stage u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_ready  (rsp_ready),
    .rd_en      (rd_en),
    .standby_in (sb_next),
    .req_ready  (req_ready),
    .accept     (accept),
    .rsp_valid  (rsp_valid),
    .lane_oe    (rsp_lane_oe),
    .standby    (standby)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    dbs_byte_bank #(.ADDR_W(ADDR_W), .W(LANE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .wr_en  (wr_en[k]),
      .rd_en  (rd_en[k]),
      .addr   (req_addr),
      .wdata  (req_wdata[k*LANE_W +: LANE_W]),
      .q      (rsp_rdata[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dual_bank_sram_chk.sv
module dual_bank_sram_chk
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [HALVES-1:0] req_cs_n,
  input logic [LANES-1:0]  req_bs_n,
  input logic              req_we_n,
  input logic              req_oe_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [LANES-1:0]  rsp_lane_oe,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              standby
);
  logic              acc;
  logic [DATA_W-1:0] drive_mask;
  logic [ADDR_W-1:0] addr_unused;

  assign acc         = req_valid && req_ready;
  assign addr_unused = req_addr;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      drive_mask[k*LANE_W +: LANE_W] = {LANE_W{rsp_lane_oe[k]}};
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_lane_oe) && $stable(standby));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_write_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_we_n |=> rsp_lane_oe == '0);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_we_n && req_oe_n |=> rsp_lane_oe == '0);

  p_low_half_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_cs_n[0] |=> rsp_lane_oe[LANES_PER_HALF-1:0] == '0);

  p_high_half_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_cs_n[1] |=> rsp_lane_oe[LANES-1:LANES_PER_HALF] == '0);

  p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> standby == $past(&req_cs_n));

  p_lane_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_lane_oe & $past(req_bs_n)) == '0);

  p_undriven_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata & ~drive_mask) == '0);
endmodule

bind dual_bank_sram dual_bank_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_cs_n    (req_cs_n),
  .req_bs_n    (req_bs_n),
  .req_we_n    (req_we_n),
  .req_oe_n    (req_oe_n),
  .req_addr    (req_addr),
  .rsp_rdata   (rsp_rdata),
  .rsp_lane_oe (rsp_lane_oe),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .standby     (standby)
);

// File: tb/sim_dual_bank_sram.sv
module sim_dual_bank_sram;
  localparam int AW   = 10;
  localparam int TOPA = (1 << AW) - 1;

  typedef struct {
    logic [31:0] data;
    logic [3:0]  oe;
    logic        sb;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cs_n = 2'b11;
  logic [3:0]  req_bs_n = 4'hF;
  logic        req_we_n = 1'b1;
  logic        req_oe_n = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [3:0]  rsp_lane_oe;
  logic        standby;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] shadow [0:TOPA];
  exp_t q[$];

  always #2 clk = ~clk;

  dual_bank_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs_n(req_cs_n), .req_bs_n(req_bs_n), .req_we_n(req_we_n), .req_oe_n(req_oe_n),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_lane_oe(rsp_lane_oe), .standby(standby)
  );

  // Driver: presents one access, records its expected response once accepted.
  task automatic issue(input logic [1:0] cs, input logic [3:0] bs, input logic we,
                       input logic oe, input logic [AW-1:0] a, input logic [31:0] d,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_cs_n = cs; req_bs_n = bs;
    req_we_n = we; req_oe_n = oe; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    e.tag = tag;
    e.sb  = &cs;
    for (int k = 0; k < 4; k++) begin
      logic en;
      logic drv;
      en  = !cs[k/2] && !bs[k];
      drv = en && we && !oe;
      if (en && !we) shadow[a][k*8 +: 8] = d[k*8 +: 8];
      e.oe[k] = drv;
      e.data[k*8 +: 8] = drv ? shadow[a][k*8 +: 8] : 8'h00;
    end
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each taken response and checks stall behaviour.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid && rsp_ready) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected response data %h exp none", rsp_rdata);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (rsp_rdata !== e.data || rsp_lane_oe !== e.oe || standby !== e.sb) begin
            errors++;
            $display("FAIL %s data %h oe %b sb %b exp data %h oe %b sb %b",
                     e.tag, rsp_rdata, rsp_lane_oe, standby, e.data, e.oe, e.sb);
          end
        end
      end else if (rsp_valid && !rsp_ready) begin
        checks++;
        if (req_ready !== 1'b0) begin
          errors++;
          $display("FAIL R9 req_ready during stall %b exp 0", req_ready);
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rsp_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R9 watchdog expired, pending %0d exp 0", q.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    checks++;
    if (rsp_valid !== 1'b0 || rsp_lane_oe !== 4'h0 || standby !== 1'b1 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 valid %b oe %b sb %b rdy %b exp 0 0000 1 1",
               rsp_valid, rsp_lane_oe, standby, req_ready);
    end
    rst_n = 1'b1;

    // R1: full words at both address extremes
    issue(2'b00, 4'h0, 1'b0, 1'b1, '0, 32'hA5A5_0F0F, "R1");
    issue(2'b00, 4'h0, 1'b0, 1'b1, AW'(TOPA), 32'h1234_5678, "R1");
    issue(2'b00, 4'h0, 1'b1, 1'b0, '0, 32'h0, "R1");
    issue(2'b00, 4'h0, 1'b1, 1'b0, AW'(TOPA), 32'h0, "R1");

    // R3 and R4: single-lane writes with output enable low (ignored)
    for (int k = 0; k < 4; k++)
      issue(2'b00, ~(4'h1 << k), 1'b0, 1'b0, AW'(12'h155), {4{8'h11 * 8'(k + 1)}}, "R4");
    issue(2'b00, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R3");

    // R5: read lanes 0 and 2 only
    issue(2'b00, 4'b1010, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R5");

    // R6: both enables high, nothing happens, then confirm content
    issue(2'b00, 4'h0, 1'b1, 1'b1, AW'(12'h155), 32'hDEAD_BEEF, "R6");
    issue(2'b00, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R6");

    // R7 and R2: one half deselected
    issue(2'b01, 4'h0, 1'b0, 1'b1, AW'(12'h155), 32'hFFFF_FFFF, "R7");
    issue(2'b00, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R7");
    issue(2'b10, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R2");
    issue(2'b01, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R2");

    // R8: whole device in standby
    issue(2'b11, 4'h0, 1'b0, 1'b1, AW'(12'h155), 32'h0, "R8");
    issue(2'b11, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R8");
    issue(2'b00, 4'h0, 1'b1, 1'b0, AW'(12'h155), 32'h0, "R8");

    // R9: random traffic under back-pressure
    bp = 1'b1;
    for (int a = 0; a < 16; a++)
      issue(2'b00, 4'h0, 1'b0, 1'b1, AW'(a), $urandom, "R9");
    for (int n = 0; n < 300; n++)
      issue(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)), $urandom, "R9");
    idle();
    bp = 1'b0;

    for (int w = 0; w < 50 && q.size() != 0; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9 responses outstanding %0d exp 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule